// File: doc/BRIEF.md
# PPS Time-Interval Gate Sequencer

This block links a one-pulse-per-second input to a time-to-analog front end that runs from a reference clock, nominally 10 MHz. The rising edge of the pulse starts the analog charge window. The block catches that edge in a capture flop, which also lengthens a short pulse. It then moves the edge into the clock domain through a shift register. The synchronized copy drives a charge-stop enable, which ends the window at a clock edge. The time between the raw edge and that clock edge is the interval to be measured.

Later taps of the same shift register count out a settling delay. After the delay, the block sends a single-cycle strobe that starts the ADC conversion. The ADC stays in sample mode while charging is under way. Sample mode drops when the conversion starts and returns once the shift register has fully drained. A one-cycle status pulse marks the end of each sequence. A pulse edge that arrives while a sequence is still running is dropped, and a sticky flag records that it happened.

Top module: `pps_gate_seq`

## Requirements
- R1: A pulse-input high pulse shorter than one clock period still produces a complete sequence, the same as a wide pulse.
- R2: With default parameters, `charge_stop_en` goes high on the third rising clock edge after the pulse-input rising edge. That is two synchronizer stages plus one gate stage.
- R3: `adc_start` is high for exactly one clock cycle, on clock edge TAP_N+1 after the pulse edge. With the default TAP_N=8 this is edge 9. It is never high while `charge_stop_en` is low.
- R4: `sample_mode` is high out of reset. It goes low on the same edge on which `adc_start` is asserted, and it goes high again on the edge that completes the sequence.
- R5: With default parameters, the sequence completes on edge 13 after the pulse edge. On that edge `charge_stop_en` goes low and `seq_done` is high for one cycle.
- R6: A pulse-input edge whose synchronized copy arrives while the delay chain is still occupied gives no extra strobe and does not change the running sequence's timing. It sets `overrun`, and `overrun` stays high until reset.
- R7: A pulse edge that arrives after a sequence has completed starts a new sequence with the same timing. This holds even while `overrun` is set.
- R8: A synchronous active-high reset clears the shift register and the capture flop. After the reset edge, `charge_stop_en`, `adc_start`, `seq_done` and `overrun` are low and `sample_mode` is high. A sequence that was under way when reset came produces no later strobe.
- R9: A pulse input held high for many cycles produces exactly one sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Asynchronous one-pulse-per-second input |
| charge_stop_en | output | 1 | Enable that ends the charge window; held until the sequence completes |
| adc_start | output | 1 | One-cycle ADC conversion strobe |
| sample_mode | output | 1 | High while the ADC should track its input |
| seq_done | output | 1 | One-cycle pulse when a sequence completes |
| overrun | output | 1 | Sticky flag: a pulse edge was dropped |

## Verification
The bench drives a pulse that is narrower than a clock period. If the capture flop did not stretch the pulse, no enable and no strobe would follow. It also holds the input high for thirty cycles. If the block reacted to the input level instead of the edge, the extra cycles would start repeated sequences. In one test a second edge lands in the middle of a sequence. A design without the occupancy gate would issue a second strobe or keep the enable high longer, and a design whose flag was not sticky would lose `overrun` in the next sequence. In another test reset is applied in mid-sequence. If the shift register were not cleared, a stray strobe would appear later.

// File: rtl/pps_seq_pkg.sv
package pps_seq_pkg;

    typedef struct packed {
        logic pass;
        logic prev_sync;
        logic charge;
        logic adc_start;
        logic sample;
        logic done;
        logic overrun;
        logic clr;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{
        pass:      1'b0,
        prev_sync: 1'b0,
        charge:    1'b0,
        adc_start: 1'b0,
        sample:    1'b1,
        done:      1'b0,
        overrun:   1'b0,
        clr:       1'b1
    };

endpackage

// File: rtl/pps_edge_catch.sv
module pps_edge_catch (
    input  logic pps_in,
    input  logic clr,
    output logic caught
);

    logic caught_q;

    // Set by the pulse edge itself; cleared from the clock domain once the
    // synchronizer holds the event, which stretches arbitrarily narrow pulses.
    always_ff @(posedge pps_in or posedge clr) begin
        if (clr) caught_q <= 1'b0;
        else     caught_q <= 1'b1;
    end

    assign caught = caught_q;

endmodule

// File: rtl/pps_delay_chain.sv
module pps_delay_chain #(
    parameter int SYNC_STAGES = 2,
    parameter int TAP_N       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             caught,
    input  logic             gate_open,
    output logic [TAP_N:0]   chain
);

    localparam int LEN = TAP_N + 1;

    logic [LEN-1:0] chain_d, chain_q;

    genvar g;
    generate
        for (g = 0; g < LEN; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_comb chain_d[g] = caught;
            end else if (g == SYNC_STAGES) begin : g_gate
                always_comb chain_d[g] = chain_q[g-1] & gate_open;
            end else begin : g_shift
                always_comb chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign chain = chain_q;

endmodule

// File: rtl/pps_seq_ctrl.sv
module pps_seq_ctrl
    import pps_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TAP_N       = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TAP_N-SYNC_STAGES+1:0] taps,
    output logic                         gate_open,
    output logic                         clr,
    output logic                         charge_stop_en,
    output logic                         adc_start,
    output logic                         sample_mode,
    output logic                         seq_done,
    output logic                         overrun
);

    localparam int W = TAP_N - SYNC_STAGES + 2;

    seq_state_t q, d;
    logic sync_hi, rise, busy, feed;

    always_comb begin
        sync_hi = taps[0];
        rise    = sync_hi & ~q.prev_sync;
        busy    = |taps[W-1:1];
        d       = q;

        d.prev_sync = sync_hi;
        d.clr       = sync_hi;
        d.pass      = rise ? ~busy : (sync_hi & q.pass);
        feed        = sync_hi & d.pass;
        d.overrun   = q.overrun | (rise & busy);
        d.adc_start = taps[W-2] & ~taps[W-1];
        d.done      = q.charge & ~busy & ~feed;
        d.charge    = (q.charge | feed) & ~d.done;
        d.sample    = d.adc_start ? 1'b0 : (q.sample | d.done);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= SEQ_RESET;
        else     q <= d;
    end

    assign gate_open      = d.pass;
    assign clr            = q.clr;
    assign charge_stop_en = q.charge;
    assign adc_start      = q.adc_start;
    assign sample_mode    = q.sample;
    assign seq_done       = q.done;
    assign overrun        = q.overrun;

    // R3
    adc_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    // R3
    adc_inside_window_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> charge_stop_en);

    // R4
    converting_only_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_mode |-> charge_stop_en);

    // R5
    done_closes_window_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (sample_mode && !charge_stop_en));

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/pps_gate_seq.sv
module pps_gate_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int TAP_N       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_in,
    output logic charge_stop_en,
    output logic adc_start,
    output logic sample_mode,
    output logic seq_done,
    output logic overrun
);

    logic             caught, clr, gate_open;
    logic [TAP_N:0]   chain;

    pps_edge_catch u_catch (
        .pps_in (pps_in),
        .clr    (clr),
        .caught (caught)
    );

    pps_delay_chain #(
        .SYNC_STAGES (SYNC_STAGES),
        .TAP_N       (TAP_N)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .caught    (caught),
        .gate_open (gate_open),
        .chain     (chain)
    );

    pps_seq_ctrl #(
        .SYNC_STAGES (SYNC_STAGES),
        .TAP_N       (TAP_N)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .taps           (chain[TAP_N:SYNC_STAGES-1]),
        .gate_open      (gate_open),
        .clr            (clr),
        .charge_stop_en (charge_stop_en),
        .adc_start      (adc_start),
        .sample_mode    (sample_mode),
        .seq_done       (seq_done),
        .overrun        (overrun)
    );

endmodule

// File: tb/sim_pps_gate_seq.sv
module sim_pps_gate_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pps_in = 1'b0;
    logic charge_stop_en, adc_start, sample_mode, seq_done, overrun;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    pps_gate_seq u0 (
        .clk            (clk),
        .rst            (rst),
        .pps_in         (pps_in),
        .charge_stop_en (charge_stop_en),
        .adc_start      (adc_start),
        .sample_mode    (sample_mode),
        .seq_done       (seq_done),
        .overrun        (overrun)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Checks all outputs after edge k of a nominal sequence.
    task automatic check_timeline(input string req, input int k, input logic exp_ovr);
        check({req, " R2"}, "charge_stop_en", charge_stop_en, (k >= 3 && k <= 12));
        check({req, " R3"}, "adc_start", adc_start, (k == 9));
        check({req, " R4"}, "sample_mode", sample_mode, !(k >= 9 && k <= 12));
        check({req, " R5"}, "seq_done", seq_done, (k == 13));
        check({req, " R6"}, "overrun", overrun, exp_ovr);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "charge_stop_en", charge_stop_en, 1'b0);
        check("R8", "adc_start", adc_start, 1'b0);
        check("R8", "seq_done", seq_done, 1'b0);
        check("R8", "overrun", overrun, 1'b0);
        check("R8", "sample_mode", sample_mode, 1'b1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Single pulse; width_ns > 0 gives a sub-period pulse, else held for hold cycles.
    task automatic t_single(input string req, input int width_ns, input int hold,
                            input int last, input logic ovr);
        int starts = 0;
        @(negedge clk);
        #2 pps_in = 1'b1;
        if (width_ns > 0) begin
            #(width_ns) pps_in = 1'b0;
        end
        for (int k = 1; k <= last; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (adc_start) starts++;
            check_timeline(req, k, ovr);
            if (k == hold) pps_in = 1'b0;
        end
        check({req, " R3"}, "one strobe per edge", starts == 1, 1'b1);
    endtask

    task automatic t_overrun;
        int starts = 0;
        @(negedge clk);
        #2 pps_in = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (adc_start) starts++;
            check_timeline("R6", k, (k >= 9));
            if (k == 4) pps_in = 1'b0;
            if (k == 6) begin
                #2 pps_in = 1'b1;
            end
            if (k == 8) pps_in = 1'b0;
        end
        check("R6", "second edge ignored", starts == 1, 1'b1);
    endtask

    task automatic t_reset_mid;
        int starts = 0;
        @(negedge clk);
        #2 pps_in = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (adc_start) starts++;
            if (k == 5) begin
                check("R8", "charge_stop_en after reset", charge_stop_en, 1'b0);
                check("R8", "sample_mode after reset", sample_mode, 1'b1);
                check("R8", "overrun after reset", overrun, 1'b0);
                rst = 1'b0;
            end
            if (k > 5) check("R8", "no late activity", charge_stop_en | adc_start | seq_done, 1'b0);
            if (k == 3) pps_in = 1'b0;
            if (k == 4) rst = 1'b1;
        end
        check("R8", "abandoned sequence strobes", starts == 0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_single("R2", 0, 5, 16, 1'b0);
        t_single("R1", 1, 0, 16, 1'b0);
        t_single("R9", 0, 30, 40, 1'b0);
        t_overrun();
        t_single("R7", 0, 4, 16, 1'b1);
        t_reset_mid();
        t_single("R7", 0, 3, 16, 1'b0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule